// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a 32-bit register bus and a 1024-byte one-time-programmable storage array. Software chooses a byte and a bit position through an address register. It then issues commands through a command register. A read command copies the chosen array byte into a data register. A program command sets one bit in the array and can never clear one. A program command only takes effect when a specific pair of command words arrives as two consecutive command writes.

The status register reports completion through a ready flag and a done flag. Software clears the done flag by writing a 1 to it. The configuration register holds a disable flag and an eight-bit lock field. Both are sticky once set, and each lock bit freezes two other configuration bits. The register bus uses word indices and a single-cycle write strobe. Read data is combinational from the index. The array port offers a combinational byte read and a one-cycle byte write.

A small state machine tracks the command sequence. Its states are IDLE, ARMED, READ_OP and PROG_OP. Its transitions are:

- **arm**: any state moves to ARMED when 0x00000001 is written to the command register.
- **fire_read**: any state moves to READ_OP when 0x00000002 is written.
- **fire_prog**: ARMED moves to PROG_OP when 0xBF79E5D0 is written.
- **break**: any state moves to IDLE when any other command word is written, including 0xBF79E5D0 outside ARMED.
- **done**: READ_OP or PROG_OP returns to IDLE after one cycle when no command is written.

Top module: `otp_ctl`

## Requirements
- R1: After reset, status (index 0) reads 0x00000001, configuration (index 3) reads 0x20000000, and address (index 1), data (index 2) and command (index 5) read 0. Reset also leaves the command sequence unarmed.
- R2: Writing 0x00000002 to the command register (index 5) starts a read. In the following cycle, the data register holds the array byte selected by address bits 9..0 in bits 7..0, and status bits 1 (done) and 0 (ready) are both 1.
- R3: Writing 0x00000001 and then 0xBF79E5D0 to the command register, with no other command write between them, programs the array. One cycle later the array port writes the selected byte with the bit at address bits 12..10 set, and both status bits 1..0 become 1. Array bits are only ever set, and writes to other registers between the two words do not disturb the sequence.
- R4: Any command word other than 0x00000001 breaks the sequence, and so does a reset. A later 0xBF79E5D0 then changes nothing. A repeated 0x00000001 keeps the sequence armed.
- R5: Status bits 1..0 cannot be written directly. Writing 1 to bit 1 clears the done flag. Bits 31..2, including the interrupt-enable bit 2, read back as written.
- R6: The data register is cleared only by writing exactly 0x00000001; any other write leaves it unchanged.
- R7: Configuration bit 31 (disable) and bits 23..16 (lock field) are sticky: once set, only a reset clears them.
- R8: While lock bit 16+k is set, configuration bits k and 8+k keep their value. All other configuration bits, including bit 29, take the written value.
- R9: The command register reads 0. Indices 4, 6 and 7 read 0 and ignore writes.
- R10: When a read completes in the same cycle as a bus write, the completion wins. A done-clear write to status leaves bits 1..0 at 1. A clear write to data still leaves the array byte in the data register.
- R11: The address register reads back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register word index |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| arr_addr | output | 10 | Array byte address |
| arr_rdata | input | 8 | Array byte read data (combinational) |
| arr_wen | output | 1 | Array byte write strobe |
| arr_wdata | output | 8 | Array byte write data |

## Verification
An array read completes one cycle after its command is written. In that same cycle, the bus can carry a write that clears the done flag or clears the data register. The bench provokes both collisions by issuing the command write and the conflicting write on consecutive cycles. It then judges the result by reading status as 0x3 and the data register as the array byte. Assertions also check that every array write follows a second-word command in the previous cycle and sets at most one new bit.

// File: rtl/otp_ctl_pkg.sv
package otp_ctl_pkg;

    localparam int REG_W     = 32;
    localparam int IDX_W     = 3;
    localparam int LK_W      = 8;

    localparam logic [IDX_W-1:0] IDX_STAT = 3'd0;
    localparam logic [IDX_W-1:0] IDX_ADDR = 3'd1;
    localparam logic [IDX_W-1:0] IDX_DATA = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CFG  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_CMD  = 3'd5;

    localparam logic [REG_W-1:0] CMD_READ   = 32'h0000_0002;
    localparam logic [REG_W-1:0] CMD_ARM    = 32'h0000_0001;
    localparam logic [REG_W-1:0] CMD_FIRE   = 32'hBF79_E5D0;
    localparam logic [REG_W-1:0] DATA_CLEAR = 32'h0000_0001;

    localparam logic [REG_W-1:0] STAT_RST = 32'h0000_0001;
    localparam logic [REG_W-1:0] CFG_RST  = 32'h2000_0000;

    localparam int CFG_RDLK_LO = 0;
    localparam int CFG_PGLK_LO = 8;
    localparam int CFG_LK_LO   = 16;
    localparam int CFG_DIS_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_READ_OP,
        ST_PROG_OP
    } cmd_state_e;

endpackage

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [REG_W-1:0] cmd_wdata,
    output logic             op_read,
    output logic             op_prog
);

    cmd_state_e state_q;
    cmd_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, fire_read, fire_prog, break, done
    always_comb begin
        state_d = state_q;
        if (cmd_we) begin
            if (cmd_wdata == CMD_READ) begin
                state_d = ST_READ_OP;
            end else if (cmd_wdata == CMD_ARM) begin
                state_d = ST_ARMED;
            end else if (cmd_wdata == CMD_FIRE && state_q == ST_ARMED) begin
                state_d = ST_PROG_OP;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_READ_OP: state_d = ST_IDLE;
                ST_PROG_OP: state_d = ST_IDLE;
                ST_IDLE:    state_d = ST_IDLE;
                ST_ARMED:   state_d = ST_ARMED;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        op_read = 1'b0;
        op_prog = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ARMED:   ;
            ST_READ_OP: op_read = 1'b1;
            ST_PROG_OP: op_prog = 1'b1;
        endcase
    end

endmodule

// File: rtl/otp_cfg_lock.sv
module otp_cfg_lock
    import otp_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_q
);

    localparam logic [REG_W-1:0] STICKY_MASK =
        (REG_W'(1) << CFG_DIS_BIT) | (REG_W'({LK_W{1'b1}}) << CFG_LK_LO);

    logic [REG_W-1:0] hold_mask;
    logic [REG_W-1:0] cfg_d;

    // Each lock bit freezes one bit of each locked field
    for (genvar k = 0; k < REG_W; k++) begin : g_mask
        if (k >= CFG_RDLK_LO && k < CFG_RDLK_LO + LK_W) begin : g_rd
            assign hold_mask[k] = cfg_q[CFG_LK_LO + k - CFG_RDLK_LO];
        end else if (k >= CFG_PGLK_LO && k < CFG_PGLK_LO + LK_W) begin : g_pg
            assign hold_mask[k] = cfg_q[CFG_LK_LO + k - CFG_PGLK_LO];
        end else begin : g_free
            assign hold_mask[k] = 1'b0;
        end
    end

    always_comb begin
        cfg_d = (cfg_q & STICKY_MASK)
              | (cfg_q & hold_mask)
              | (cfg_wdata & ~hold_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (cfg_we) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/otp_bit_setter.sv
module otp_bit_setter #(
    parameter int BYTE_W = 8,
    localparam int POS_W = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] old_byte,
    input  logic [POS_W-1:0]  bit_pos,
    output logic [BYTE_W-1:0] new_byte
);

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign new_byte[b] = old_byte[b] | (bit_pos == POS_W'(b));
    end

endmodule

// File: rtl/otp_ctl.sv
module otp_ctl
    import otp_ctl_pkg::*;
#(
    parameter int ARR_BYTES = 1024,
    parameter int BYTE_W    = 8,
    localparam int ARR_AW   = $clog2(ARR_BYTES),
    localparam int POS_W    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic              bus_wen,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [ARR_AW-1:0] arr_addr,
    input  logic [BYTE_W-1:0] arr_rdata,
    output logic              arr_wen,
    output logic [BYTE_W-1:0] arr_wdata
);

    logic [REG_W-1:0] fst_q;
    logic [REG_W-1:0] faddr_q;
    logic [REG_W-1:0] fdata_q;
    logic [REG_W-1:0] fcfg_q;
    logic [REG_W-1:0] fst_d;

    logic we_stat, we_addr, we_data, we_cfg, we_cmd;
    logic op_read, op_prog;

    assign we_stat = bus_wen && (bus_addr == IDX_STAT);
    assign we_addr = bus_wen && (bus_addr == IDX_ADDR);
    assign we_data = bus_wen && (bus_addr == IDX_DATA);
    assign we_cfg  = bus_wen && (bus_addr == IDX_CFG);
    assign we_cmd  = bus_wen && (bus_addr == IDX_CMD);

    otp_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (we_cmd),
        .cmd_wdata (bus_wdata),
        .op_read   (op_read),
        .op_prog   (op_prog)
    );

    otp_cfg_lock u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (we_cfg),
        .cfg_wdata (bus_wdata),
        .cfg_q     (fcfg_q)
    );

    assign arr_addr = faddr_q[ARR_AW-1:0];
    assign arr_wen  = op_prog;

    otp_bit_setter #(.BYTE_W(BYTE_W)) u_set (
        .old_byte (arr_rdata),
        .bit_pos  (faddr_q[ARR_AW +: POS_W]),
        .new_byte (arr_wdata)
    );

    // Status: ready/done are not directly writable, done clears on write-1
    always_comb begin
        fst_d = fst_q;
        if (we_stat) begin
            fst_d = {bus_wdata[REG_W-1:2], fst_q[1] & ~bus_wdata[1], fst_q[0]};
        end
        if (op_read || op_prog) begin
            fst_d[1:0] = 2'b11;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst_q   <= STAT_RST;
            faddr_q <= '0;
            fdata_q <= '0;
        end else begin
            fst_q <= fst_d;
            if (we_addr) begin
                faddr_q <= bus_wdata;
            end
            if (op_read) begin
                fdata_q <= REG_W'(arr_rdata);
            end else if (we_data && bus_wdata == DATA_CLEAR) begin
                fdata_q <= '0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            IDX_STAT: bus_rdata = fst_q;
            IDX_ADDR: bus_rdata = faddr_q;
            IDX_DATA: bus_rdata = fdata_q;
            IDX_CFG:  bus_rdata = fcfg_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/otp_ctl_chk.sv
module otp_ctl_chk
    import otp_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] bus_addr,
    input logic             bus_wen,
    input logic [REG_W-1:0] bus_wdata,
    input logic             arr_wen,
    input logic [7:0]       arr_rdata,
    input logic [7:0]       arr_wdata,
    input logic [REG_W-1:0] fst_q,
    input logic [REG_W-1:0] fdata_q,
    input logic [REG_W-1:0] fcfg_q
);

    assert_prog_after_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wen |-> $past(bus_wen && bus_addr == IDX_CMD && bus_wdata == CMD_FIRE));

    assert_set_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wen |-> (((arr_rdata & ~arr_wdata) == 8'h00)
                     && ($countones(arr_wdata ^ arr_rdata) <= 1)));

    assert_prog_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wen |=> (fst_q[1:0] == 2'b11));

    assert_ready_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fst_q[0]) |-> fst_q[0]);

    assert_dis_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fcfg_q[31]) |-> fcfg_q[31]);

    assert_lk_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fcfg_q[23:16]) & ~fcfg_q[23:16]) == 8'h00));

    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(fcfg_q[23:16]) & ($past(fcfg_q[15:8]) ^ fcfg_q[15:8])) == 8'h00)
         && (($past(fcfg_q[23:16]) & ($past(fcfg_q[7:0]) ^ fcfg_q[7:0])) == 8'h00)));

    assert_data_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fdata_q) |->
            ($past(bus_wen && bus_addr == IDX_DATA && bus_wdata == DATA_CLEAR)
             || $past(bus_wen && bus_addr == IDX_CMD && bus_wdata == CMD_READ, 2)));

endmodule

bind otp_ctl otp_ctl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .arr_wen   (arr_wen),
    .arr_rdata (arr_rdata),
    .arr_wdata (arr_wdata),
    .fst_q     (fst_q),
    .fdata_q   (fdata_q),
    .fcfg_q    (fcfg_q)
);

// File: tb/otp_ctl_tb.sv
module otp_ctl_tb_top;

    localparam int NV = 63;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_ID = 2'd2;
    localparam logic [31:0] FIRE = 32'hBF79_E5D0;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{OP_RD, 3'd0, 32'h0, 32'h0000_0001, 4'd1},   // R1
        '{OP_RD, 3'd3, 32'h0, 32'h2000_0000, 4'd1},   // R1
        '{OP_WR, 3'd1, 32'h3, 32'h0, 4'd0},
        '{OP_RD, 3'd1, 32'h0, 32'h3, 4'd11},          // R11
        '{OP_WR, 3'd5, 32'h2, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'h74, 4'd2},          // R2
        '{OP_RD, 3'd0, 32'h0, 32'h3, 4'd2},           // R2
        '{OP_WR, 3'd0, 32'h2, 32'h0, 4'd0},
        '{OP_RD, 3'd0, 32'h0, 32'h1, 4'd5},           // R5
        '{OP_WR, 3'd0, 32'h7, 32'h0, 4'd0},
        '{OP_RD, 3'd0, 32'h0, 32'h5, 4'd5},           // R5
        '{OP_WR, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd0, 32'h0, 32'h1, 4'd5},           // R5
        '{OP_WR, 3'd2, 32'h3, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'h74, 4'd6},          // R6
        '{OP_WR, 3'd2, 32'h1, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'h0, 4'd6},           // R6
        '{OP_WR, 3'd1, 32'h1C10, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h1, 32'h0, 4'd0},
        '{OP_WR, 3'd5, FIRE, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h2, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'hD5, 4'd3},          // R3
        '{OP_WR, 3'd1, 32'h1410, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h1, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h3, 32'h0, 4'd0},
        '{OP_WR, 3'd5, FIRE, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h2, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'hD5, 4'd4},          // R4
        '{OP_WR, 3'd5, 32'h1, 32'h0, 4'd0},
        '{OP_WR, 3'd1, 32'h1410, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h1, 32'h0, 4'd0},
        '{OP_WR, 3'd5, FIRE, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_WR, 3'd5, 32'h2, 32'h0, 4'd0},
        '{OP_ID, 3'd0, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'hF5, 4'd3},          // R3 (and R4 re-arm)
        '{OP_WR, 3'd3, 32'h0001_00FF, 32'h0, 4'd0},
        '{OP_RD, 3'd3, 32'h0, 32'h0001_00FF, 4'd8},   // R8
        '{OP_WR, 3'd3, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd3, 32'h0, 32'h0001_0001, 4'd8},   // R8
        '{OP_WR, 3'd3, 32'h8000_FFFE, 32'h0, 4'd0},
        '{OP_RD, 3'd3, 32'h0, 32'h8001_FEFF, 4'd8},   // R8
        '{OP_WR, 3'd3, 32'h0, 32'h0, 4'd0},
        '{OP_RD, 3'd3, 32'h0, 32'h8001_0001, 4'd7},   // R7
        '{OP_WR, 3'd4, 32'hFFFF_FFFF, 32'h0, 4'd0},
        '{OP_RD, 3'd4, 32'h0, 32'h0, 4'd9},           // R9
        '{OP_RD, 3'd7, 32'h0, 32'h0, 4'd9},           // R9
        '{OP_WR, 3'd5, 32'h1, 32'h0, 4'd0},
        '{OP_RD, 3'd5, 32'h0, 32'h0, 4'd9},           // R9
        '{OP_WR, 3'd5, 32'h0, 32'h0, 4'd0},
        '{OP_WR, 3'd0, 32'h2, 32'h0, 4'd0},
        '{OP_RD, 3'd0, 32'h0, 32'h1, 4'd5},           // R5
        '{OP_WR, 3'd5, 32'h2, 32'h0, 4'd0},
        '{OP_WR, 3'd0, 32'h2, 32'h0, 4'd0},
        '{OP_RD, 3'd0, 32'h0, 32'h3, 4'd10},          // R10
        '{OP_WR, 3'd5, 32'h2, 32'h0, 4'd0},
        '{OP_WR, 3'd2, 32'h1, 32'h0, 4'd0},
        '{OP_RD, 3'd2, 32'h0, 32'hF5, 4'd10}          // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  arr_addr;
    logic [7:0]  arr_rdata;
    logic        arr_wen;
    logic [7:0]  arr_wdata;

    logic [7:0] mem [1024];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    otp_ctl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .arr_addr  (arr_addr),
        .arr_rdata (arr_rdata),
        .arr_wen   (arr_wen),
        .arr_wdata (arr_wdata)
    );

    assign arr_rdata = mem[arr_addr];
    always_ff @(posedge clk) begin
        if (arr_wen) mem[arr_addr] <= arr_wdata;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        bus_addr = idx; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        bus_wen = 1'b0; bus_addr = idx;
        #1;
        check(tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wen = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 5) & 8'hFF);
        @(negedge clk);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_WR: wr(VECS[i].idx, VECS[i].data);
                OP_RD: rd(VECS[i].idx, VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i));
                default: idle();
            endcase
        end
        // Directed: sequence armed before reset must not survive it (R4)
        wr(3'd1, 32'h0410);
        wr(3'd5, 32'h1);
        do_reset();
        rd(3'd0, 32'h1, "R1 status after reset");
        rd(3'd3, 32'h2000_0000, "R1 cfg after reset");
        rd(3'd1, 32'h0, "R1 addr after reset");
        rd(3'd2, 32'h0, "R1 data after reset");
        rd(3'd5, 32'h0, "R1 cmd after reset");
        wr(3'd1, 32'h0410);
        wr(3'd5, FIRE);
        idle();
        wr(3'd5, 32'h2);
        idle();
        rd(3'd2, 32'hF5, "R4 fire after reset ignored");
        rd(3'd0, 32'h3, "R2 flags after read");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule